// File: doc/BRIEF.md
# Guarded SPI Configuration Register Front-End

This block is the serial register front-end of a supervisory chip. A host reaches it over a 16-bit, full-duplex SPI link (clock idles low, data sampled on the rising clock edge, shifted out on the falling edge, most significant bit first). Each frame is decoded into a read or a write. A frame with a parity error, a frame that is not exactly 16 bits long, and a write to a missing or read-only address are all discarded. The faults among these raise sticky error flags and a one-cycle interrupt request.

Settings that matter for safety are guarded in two ways. A control setting and an output setting change only through a complementary double write. The host first writes the value to one register and then writes the bitwise inverse of that value to its companion register. A failed attempt raises a separate protocol flag for each pair. A configuration setting is staged in a writable request register and shown in a read-only active register. The request is promoted to the active register only after four protection keys have been written in order. The lock closes again after one promotion.

Frame layout: bit 15 is the write flag (1 = write). Bits 14:9 hold the address, bits 8:1 hold the data byte, and bit 0 is the parity bit. The MISO word sent during a frame carries the error flags in bits 15:8 and the data byte of the last valid read in bits 7:0.

Top module: `spi_prot_regs`

## Requirements
- R1: Only a frame of exactly 16 clock pulses between chip-select fall and rise is decoded. A shorter frame has no effect on any register or flag.
- R2: A frame whose 16 bits do not hold an odd number of ones is discarded. It sets flag bit 0 and pulses the interrupt.
- R3: A write to an address other than 0x01, 0x03, 0x04, 0x05, 0x06, 0x08 or 0x0A is discarded. This includes the read-only active register at 0x02. Such a write sets flag bit 1 and pulses the interrupt.
- R4: A read returns, in bits 7:0 of the next frame's MISO word, the register read. Addresses read back as follows: 0x01 the request, 0x02 the active configuration, 0x03 the active control value, 0x05 the active output value, 0x08 the key status, 0x0A the flags. Bits 15:8 of every MISO word hold {4'b0, flags} as they stood at chip-select fall.
- R5: The active control value (port ctrl_act) takes value V only after a write of V to 0x03 is followed by a write of ~V to 0x04. The active output value (port out_act) follows the same rule with 0x05 and 0x06.
- R6: A write to 0x04 that does not carry the inverse of the pending 0x03 value, or that arrives with no pending value, leaves ctrl_act unchanged and sets flag bit 2. The same fault on the 0x05/0x06 pair sets flag bit 3.
- R7: The key register at 0x08 accepts the keys 0xA5, 0x5A, 0xC3 and 0x3C in that order. Each accepted key sets its valid bit (bits 3:0 of a 0x08 read). When all four are valid, lock_open and bit 7 of a 0x08 read are 1.
- R8: A key that is wrong or out of order clears all key-valid bits and restarts the sequence at the first key.
- R9: A write to 0x01 always stores the request. It is copied into cfg_act only while lock_open is 1, and that copy clears all key-valid bits.
- R10: A write to 0x0A clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R11: irq_pulse is high for exactly one clock cycle for each frame that sets a flag.
- R12: After reset: cfg_act = 0x00, ctrl_act = 0x01, out_act = 0x10, flags = 0, lock_open = 0, irq_pulse = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 while deselected |
| cfg_act | output | 8 | Active configuration value |
| ctrl_act | output | 8 | Active control value |
| out_act | output | 8 | Active output value |
| lock_open | output | 1 | All four keys accepted |
| err_flags | output | 4 | Sticky flags {out pair, ctrl pair, address, parity} |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that the SPI pins change slowly compared with clk, with several system clocks per SPI half period. Under that condition decoded frames are far apart, and a change on a guarded output can be traced to a decoded frame one cycle earlier. The stimulus drives all SPI pins on the falling system clock edge. It holds each SPI half period for six clocks and leaves idle gaps between frames, so no two frames ever overlap in the synchronizers.

// File: rtl/spi_prot_pkg.sv
package spi_prot_pkg;
  localparam int DW      = 8;
  localparam int AW      = 6;
  localparam int FW      = 1 + AW + DW + 1;
  localparam int NFLAG   = 4;
  localparam int NKEY    = 4;
  localparam int NPAIR   = 2;

  localparam logic [AW-1:0] A_CFG_REQ  = 6'h01;
  localparam logic [AW-1:0] A_CFG_ACT  = 6'h02;
  localparam logic [AW-1:0] A_CTRL     = 6'h03;
  localparam logic [AW-1:0] A_CTRL_INV = 6'h04;
  localparam logic [AW-1:0] A_OUT      = 6'h05;
  localparam logic [AW-1:0] A_OUT_INV  = 6'h06;
  localparam logic [AW-1:0] A_KEY      = 6'h08;
  localparam logic [AW-1:0] A_STATUS   = 6'h0A;

  localparam logic [DW-1:0] KEY_VAL [NKEY] = '{8'hA5, 8'h5A, 8'hC3, 8'h3C};

  typedef struct packed {
    logic            wr;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   data;
    logic            par;
  } frame_t;
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_prot_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [FW-1:0] tx_word,
  output logic          miso,
  output logic          frame_vld,
  output logic [FW-1:0] frame_word
);
  localparam int CW = $clog2(FW) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [1:0] cs_s, sclk_s, mosi_s;
  logic       cs_p, sclk_p;
  logic [FW-1:0] rx_q, rx_n, tx_q, tx_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          vld_q, vld_n;

  wire cs_fall   = cs_p & ~cs_s[1];
  wire cs_rise   = ~cs_p & cs_s[1];
  wire sclk_rise = ~sclk_p & sclk_s[1];
  wire sclk_fall = sclk_p & ~sclk_s[1];

  always_comb begin
    rx_n  = rx_q;
    tx_n  = tx_q;
    cnt_n = cnt_q;
    vld_n = cs_rise && (cnt_q == CW'(FW));
    if (cs_fall) begin
      cnt_n = '0;
      tx_n  = tx_word;
    end else if (!cs_s[1]) begin
      if (sclk_rise) begin
        rx_n = {rx_q[FW-2:0], mosi_s[1]};
        if (cnt_q != CMAX) cnt_n = cnt_q + 1'b1;
      end
      if (sclk_fall) tx_n = {tx_q[FW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 2'b11;
      sclk_s <= 2'b00;
      mosi_s <= 2'b00;
      cs_p   <= 1'b1;
      sclk_p <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      cs_s   <= {cs_s[0], cs_n};
      sclk_s <= {sclk_s[0], sclk};
      mosi_s <= {mosi_s[0], mosi};
      cs_p   <= cs_s[1];
      sclk_p <= sclk_s[1];
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      cnt_q  <= cnt_n;
      vld_q  <= vld_n;
    end
  end

  assign miso       = ~cs_s[1] & tx_q[FW-1];
  assign frame_vld  = vld_q;
  assign frame_word = rx_q;
endmodule

// File: rtl/spi_pair_guard.sv
module spi_pair_guard
  import spi_prot_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val,
  input  logic          wr_inv,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] act,
  output logic          perr
);
  logic          pend_q, pend_n;
  logic [DW-1:0] val_q, val_n, act_q, act_n;
  logic          match;

  always_comb begin
    match  = pend_q && (data == ~val_q);
    perr   = wr_inv && !match;
    pend_n = pend_q;
    val_n  = val_q;
    act_n  = act_q;
    if (wr_val) begin
      pend_n = 1'b1;
      val_n  = data;
    end else if (wr_inv) begin
      pend_n = 1'b0;
      if (match) act_n = val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      val_q  <= '0;
      act_q  <= RST_VAL;
    end else begin
      pend_q <= pend_n;
      val_q  <= val_n;
      act_q  <= act_n;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/spi_key_lock.sv
module spi_key_lock
  import spi_prot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_wr,
  input  logic [DW-1:0]   key_data,
  input  logic            relock,
  output logic [NKEY-1:0] key_ok,
  output logic            open
);
  localparam int IW = $clog2(NKEY);

  logic [NKEY-1:0] ok_q, ok_n;
  logic [IW-1:0]   idx_q, idx_n;

  always_comb begin
    ok_n  = ok_q;
    idx_n = idx_q;
    if (relock) begin
      ok_n  = '0;
      idx_n = '0;
    end else if (key_wr) begin
      if (key_data == KEY_VAL[idx_q]) begin
        ok_n  = ((idx_q == '0) ? '0 : ok_q) | (NKEY'(1) << idx_q);
        idx_n = idx_q + 1'b1;
      end else begin
        ok_n  = '0;
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= '0;
      idx_q <= '0;
    end else begin
      ok_q  <= ok_n;
      idx_q <= idx_n;
    end
  end

  assign key_ok = ok_q;
  assign open   = &ok_q;
endmodule

// File: rtl/spi_prot_regs.sv
module spi_prot_regs
  import spi_prot_pkg::*;
#(
  parameter logic [DW-1:0] CFG_RST  = 8'h00,
  parameter logic [DW-1:0] CTRL_RST = 8'h01,
  parameter logic [DW-1:0] OUT_RST  = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic [DW-1:0]    cfg_act,
  output logic [DW-1:0]    ctrl_act,
  output logic [DW-1:0]    out_act,
  output logic             lock_open,
  output logic [NFLAG-1:0] err_flags,
  output logic             irq_pulse
);
  localparam logic [DW-1:0] PAIR_RST [NPAIR] = '{CTRL_RST, OUT_RST};
  localparam logic [AW-1:0] PAIR_VA  [NPAIR] = '{A_CTRL, A_OUT};
  localparam logic [AW-1:0] PAIR_IA  [NPAIR] = '{A_CTRL_INV, A_OUT_INV};

  logic          frame_vld;
  logic [FW-1:0] frame_word;
  frame_t        fr;
  logic          par_ok, wr, rd, addr_ok;
  logic [NPAIR-1:0] p_wr_val, p_wr_inv, p_err;
  logic [DW-1:0]    p_act [NPAIR];
  logic [NKEY-1:0]  key_ok;
  logic             cfg_wr, key_wr, st_wr, relock;
  logic [NFLAG-1:0] ev, flags_q, flags_n;
  logic             irq_q, irq_n;
  logic [DW-1:0]    cfg_req_q, cfg_req_n, cfg_act_q, cfg_act_n;
  logic [DW-1:0]    rdata_q, rdata_n;

  spi_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .tx_word   ({{(DW-NFLAG){1'b0}}, flags_q, rdata_q}),
    .miso      (spi_miso),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  always_comb begin
    fr      = frame_t'(frame_word);
    par_ok  = ^frame_word;
    wr      = frame_vld & par_ok & fr.wr;
    rd      = frame_vld & par_ok & ~fr.wr;
    addr_ok = fr.addr inside {A_CFG_REQ, A_CTRL, A_CTRL_INV, A_OUT,
                              A_OUT_INV, A_KEY, A_STATUS};
    cfg_wr  = wr && (fr.addr == A_CFG_REQ);
    key_wr  = wr && (fr.addr == A_KEY);
    st_wr   = wr && (fr.addr == A_STATUS);
    relock  = cfg_wr & lock_open;
  end

  generate
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      assign p_wr_val[g] = wr && (fr.addr == PAIR_VA[g]);
      assign p_wr_inv[g] = wr && (fr.addr == PAIR_IA[g]);
      spi_pair_guard #(.RST_VAL(PAIR_RST[g])) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_val(p_wr_val[g]),
        .wr_inv(p_wr_inv[g]),
        .data  (fr.data),
        .act   (p_act[g]),
        .perr  (p_err[g])
      );
    end
  endgenerate

  spi_key_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .key_data(fr.data),
    .relock  (relock),
    .key_ok  (key_ok),
    .open    (lock_open)
  );

  always_comb begin
    ev        = {p_err, wr & ~addr_ok, frame_vld & ~par_ok};
    flags_n   = (flags_q & ~(st_wr ? fr.data[NFLAG-1:0] : '0)) | ev;
    irq_n     = |ev;
    cfg_req_n = cfg_wr ? fr.data : cfg_req_q;
    cfg_act_n = relock ? fr.data : cfg_act_q;
    rdata_n   = rdata_q;
    if (rd) begin
      unique case (fr.addr)
        A_CFG_REQ: rdata_n = cfg_req_q;
        A_CFG_ACT: rdata_n = cfg_act_q;
        A_CTRL:    rdata_n = p_act[0];
        A_OUT:     rdata_n = p_act[1];
        A_KEY:     rdata_n = {lock_open, {(DW-NKEY-1){1'b0}}, key_ok};
        A_STATUS:  rdata_n = {{(DW-NFLAG){1'b0}}, flags_q};
        default:   rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      irq_q     <= 1'b0;
      cfg_req_q <= CFG_RST;
      cfg_act_q <= CFG_RST;
      rdata_q   <= '0;
    end else begin
      flags_q   <= flags_n;
      irq_q     <= irq_n;
      cfg_req_q <= cfg_req_n;
      cfg_act_q <= cfg_act_n;
      rdata_q   <= rdata_n;
    end
  end

  assign cfg_act   = cfg_act_q;
  assign ctrl_act  = p_act[0];
  assign out_act   = p_act[1];
  assign err_flags = flags_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/spi_prot_regs_chk.sv
module spi_prot_regs_chk
  import spi_prot_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_vld,
  input logic [DW-1:0]    cfg_act,
  input logic [DW-1:0]    ctrl_act,
  input logic [DW-1:0]    out_act,
  input logic             lock_open,
  input logic [NFLAG-1:0] err_flags,
  input logic             irq_pulse
);
  // R9
  cfg_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_act) |-> $past(lock_open));
  // R9
  relock_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_act) |-> !lock_open);
  // R11
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (err_flags != '0));
  // R11
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R5
  ctrl_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_act) |-> $past(frame_vld));
  // R5
  out_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_act) |-> $past(frame_vld));
  // R10
  flag_clear_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_flags) & ~err_flags) != '0) |-> $past(frame_vld));
endmodule

bind spi_prot_regs spi_prot_regs_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_vld(frame_vld),
  .cfg_act  (cfg_act),
  .ctrl_act (ctrl_act),
  .out_act  (out_act),
  .lock_open(lock_open),
  .err_flags(err_flags),
  .irq_pulse(irq_pulse)
);

// File: tb/test_spi_prot_regs.sv
module test_spi_prot_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, lock_open, irq_pulse;
  logic [7:0] cfg_act, ctrl_act, out_act;
  logic [3:0] err_flags;
  int checks = 0, errors = 0, irq_cnt = 0;
  logic [15:0] resp;
  logic [7:0]  rdv;

  always #10 clk = ~clk;

  spi_prot_regs i_spi_prot_regs (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .cfg_act(cfg_act), .ctrl_act(ctrl_act), .out_act(out_act),
    .lock_open(lock_open), .err_flags(err_flags), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) if (rst_n && irq_pulse) irq_cnt++;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic w, input logic [5:0] a, input logic [7:0] d);
    return {w, a, d, ~^{w, a, d}};
  endfunction

  task automatic xfer(input logic [15:0] word, input int nbits, output logic [15:0] r);
    r = '0;
    tick(1);
    cs_n = 1'b0;
    tick(6);
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = word[i];
      tick(6);
      r = {r[14:0], miso};
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [15:0] r;
    xfer(mk(1'b1, a, d), 16, r);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    logic [15:0] r;
    xfer(mk(1'b0, a, 8'h00), 16, r);
    xfer(mk(1'b0, 6'h0A, 8'h00), 16, r);
    d = r[7:0];
  endtask

  task automatic t_reset();
    check("R12 cfg_act", cfg_act, 8'h00);
    check("R12 ctrl_act", ctrl_act, 8'h01);
    check("R12 out_act", out_act, 8'h10);
    check("R12 flags", err_flags, 0);
    check("R12 lock_open", lock_open, 0);
    check("R12 irq", irq_pulse, 0);
  endtask

  task automatic t_short_frame();
    logic [15:0] r;
    xfer(mk(1'b1, 6'h08, 8'hA5), 12, r);
    rd(6'h08, rdv);
    check("R1 short frame ignored", rdv, 8'h00);
    check("R1 short frame no flag", err_flags, 0);
  endtask

  task automatic t_parity();
    logic [15:0] r;
    int base = irq_cnt;
    xfer(mk(1'b1, 6'h08, 8'hA5) ^ 16'h0001, 16, r);
    check("R2 parity flag", err_flags, 4'b0001);
    check("R11 one irq per parity error", irq_cnt - base, 1);
    rd(6'h08, rdv);
    check("R2 bad frame discarded", rdv, 8'h00);
    xfer(mk(1'b0, 6'h0A, 8'h00), 16, r);
    check("R4 flag snapshot in high byte", r[15:8], 8'h01);
  endtask

  task automatic t_addr();
    int base = irq_cnt;
    wr(6'h02, 8'h77);
    check("R3 ro write flag", err_flags, 4'b0011);
    check("R3 cfg_act unchanged", cfg_act, 8'h00);
    wr(6'h3F, 8'h12);
    check("R11 irq count addr errors", irq_cnt - base, 2);
  endtask

  task automatic t_w1c();
    wr(6'h0A, 8'h00);
    check("R10 zero write keeps flags", err_flags, 4'b0011);
    wr(6'h0A, 8'h01);
    check("R10 clear bit0 only", err_flags, 4'b0010);
    wr(6'h0A, 8'h0F);
    check("R10 clear all", err_flags, 0);
  endtask

  task automatic t_pairs();
    wr(6'h03, 8'h5C);
    check("R5 no change after first write", ctrl_act, 8'h01);
    wr(6'h04, 8'hA3);
    check("R5 ctrl applied", ctrl_act, 8'h5C);
    check("R5 no flag", err_flags, 0);
    wr(6'h03, 8'h33);
    wr(6'h04, 8'h00);
    check("R6 ctrl mismatch unchanged", ctrl_act, 8'h5C);
    check("R6 ctrl proto flag", err_flags, 4'b0100);
    wr(6'h06, 8'h7E);
    check("R6 out inv w/o pending unchanged", out_act, 8'h10);
    check("R6 out proto flag", err_flags, 4'b1100);
    wr(6'h0A, 8'h0C);
    wr(6'h05, 8'h81);
    wr(6'h06, 8'h7E);
    check("R5 out applied", out_act, 8'h81);
    rd(6'h05, rdv);
    check("R4 read out_act", rdv, 8'h81);
    rd(6'h03, rdv);
    check("R4 read ctrl_act", rdv, 8'h5C);
  endtask

  task automatic t_keys();
    wr(6'h08, 8'hA5);
    wr(6'h08, 8'h5A);
    rd(6'h08, rdv);
    check("R7 two keys valid", rdv, 8'h03);
    wr(6'h08, 8'h3C);
    rd(6'h08, rdv);
    check("R8 out of order clears", rdv, 8'h00);
    wr(6'h08, 8'hA5);
    wr(6'h08, 8'hFF);
    rd(6'h08, rdv);
    check("R8 wrong key clears", rdv, 8'h00);
    wr(6'h01, 8'h11);
    check("R9 locked no copy", cfg_act, 8'h00);
    rd(6'h01, rdv);
    check("R9 request stored", rdv, 8'h11);
    wr(6'h08, 8'hA5);
    wr(6'h08, 8'h5A);
    wr(6'h08, 8'hC3);
    wr(6'h08, 8'h3C);
    check("R7 lock open", lock_open, 1);
    rd(6'h08, rdv);
    check("R7 status all valid", rdv, 8'h8F);
    wr(6'h01, 8'h6D);
    check("R9 copied", cfg_act, 8'h6D);
    check("R9 relocked", lock_open, 0);
    rd(6'h02, rdv);
    check("R4 read cfg_act", rdv, 8'h6D);
    wr(6'h01, 8'h22);
    check("R9 second write not copied", cfg_act, 8'h6D);
    check("R9 keys no flag", err_flags, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_short_frame();
    t_parity();
    t_addr();
    t_w1c();
    t_pairs();
    t_keys();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule